// File: doc/BRIEF.md
# Flash Word Program Engine

This block models the program path of a NOR-style flash array as ordinary synchronous logic. A decoded program strobe delivers an address and a data word. The engine captures the word's current contents and works out the value it must end up holding. It then applies one program pulse per clock to a small register-file array until the stored word matches that value. If the pulse budget runs out first, it latches a timeout status bit. A pulse can only clear bits. A request to turn a stored 0 into a 1 is dropped quietly, and the remaining 1-to-0 changes in the same word are still made.

Errors stay latched until the matching command arrives. A reset strobe clears a timeout. The engine then returns to plain array read, or to erase-suspend read if the failed program was issued inside an erase-suspend context. A separate abort status bit records an aborted buffered write, and only the dedicated abort-reset strobe clears it. While the engine is programming or holding an error, a read returns a status byte instead of array data. A test hook can pin one bit position of the programmed word so that the timeout path can be reached on purpose.

Top module: `flash_prog_engine`

## Requirements
- R1: After reset every array word reads all ones (0xFF), busy is 0, suspRead is 0 and both status bits are clear.
- R2: A program strobe accepted while idle leaves the word at old AND data. Busy rises in the cycle after the strobe and stays high until the word matches. With no stuck bit, busy lasts exactly 2 cycles.
- R3: Bits that a request would raise from 0 to 1 keep their stored 0. The 1-to-0 bits of the same request are still written.
- R4: A request that clears no stored bit finishes after exactly 1 busy cycle and does not set the timeout bit.
- R5: While busy or in an error state, rdData returns a status byte: bit 5 is the timeout bit, bit 1 is the abort bit, and all other bits are 0. When idle, rdData returns the word at rdAddr.
- R6: Program strobes that arrive while busy or in an error state are ignored and change no word.
- R7: When stuckEn is 1, bit stuckIdx of the word being programmed keeps its old value on every pulse. If the word then never matches, the timeout bit sets after PULSE_LIMIT pulses, with busy high for exactly PULSE_LIMIT+1 cycles.
- R8: The timeout bit stays set until resetCmdStb. The reset returns the engine to idle, with suspRead equal to the suspendCtx value captured when the failed request was accepted. After a successful program, suspRead likewise shows the captured context.
- R9: An abortStb while idle sets the abort bit. Only abortResetStb clears it, returning to array read with suspRead 0. resetCmdStb has no effect on it, and abortResetStb has no effect on a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| progStb | input | 1 | Decoded program request strobe |
| progAddr | input | ADDR_W | Word address of the program request |
| progData | input | DATA_W | Requested data word |
| suspendCtx | input | 1 | Request issued inside an erase-suspend context |
| resetCmdStb | input | 1 | Decoded reset command |
| abortStb | input | 1 | Buffered-write abort event |
| abortResetStb | input | 1 | Decoded abort-reset command |
| stuckEn | input | 1 | Test hook: pin one bit of the programmed word |
| stuckIdx | input | $clog2(DATA_W) | Bit position pinned by the test hook |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Array word or status byte |
| busy | output | 1 | Program operation in progress |
| suspRead | output | 1 | Idle in erase-suspend read mode |

## Verification
Program requests are tried with four data patterns on fresh and already-programmed words. A plain clear on an erased word checks the AND rule and the two-cycle busy time. A mixed pattern on a programmed word separates masking of 0-to-1 bits from the writing of 1-to-0 bits. An all-ones word that clears nothing checks the single-cycle finish and confirms that masking alone raises no timeout. A stuck bit under a clear-everything word drives the pulse limit, and that test is run with both suspend contexts so that the two reset exits can be told apart. Strobes sent while busy, in timeout and in abort, and each reset command sent in the wrong error state, are read back through the array to show they had no effect.

// File: rtl/flash_pkg.sv
package flash_pkg;

  // Bit positions inside the status byte seen on rdData
  localparam int TMO_POS = 5;
  localparam int ABT_POS = 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PROG = 2'd1,
    ST_TMO  = 2'd2,
    ST_ABT  = 2'd3
  } engState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;        // capture address, data and target word
    logic pulse;       // apply one program pulse to the captured word
    logic showStatus;  // read port returns the status byte
    logic tmoBit;
    logic abtBit;
  } engCtrl_t;

endpackage

// File: rtl/flash_ctrl.sv
module flash_ctrl
  import flash_pkg::*;
#(
  parameter int PULSE_LIMIT = 16
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     progStb,
  input  logic     suspendCtx,
  input  logic     resetCmdStb,
  input  logic     abortStb,
  input  logic     abortResetStb,
  input  logic     wordMatch,
  output engCtrl_t ctrl,
  output logic     busy,
  output logic     suspRead,
  output logic     timeoutFlag,
  output logic     abortFlag
);

  localparam int CNT_W = $clog2(PULSE_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(PULSE_LIMIT);

  engState_t  state, stateNext;
  logic [CNT_W-1:0] pulseCnt;
  logic       ctxQ;
  logic       accept;
  logic       limitHit;

  assign accept   = (state == ST_IDLE) && progStb;
  assign limitHit = (pulseCnt == LIMIT_V);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (progStb)       stateNext = ST_PROG;
        else if (abortStb) stateNext = ST_ABT;
      end
      ST_PROG: begin
        if (wordMatch)     stateNext = ST_IDLE;
        else if (limitHit) stateNext = ST_TMO;
      end
      ST_TMO: if (resetCmdStb)   stateNext = ST_IDLE;
      ST_ABT: if (abortResetStb) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pulseCnt <= '0;
      ctxQ     <= 1'b0;
    end else begin
      state <= stateNext;
      if (accept) begin
        pulseCnt <= '0;
        ctxQ     <= suspendCtx;
      end else if (state == ST_PROG && !wordMatch && !limitHit) begin
        pulseCnt <= pulseCnt + 1'b1;
      end
      // abort exit always lands in plain array read
      if (state == ST_ABT && abortResetStb) ctxQ <= 1'b0;
      else if (state == ST_IDLE && !progStb && abortStb) ctxQ <= 1'b0;
    end
  end

  always_comb begin
    ctrl            = '0;
    ctrl.load       = accept;
    ctrl.pulse      = (state == ST_PROG) && !wordMatch && !limitHit;
    ctrl.showStatus = (state != ST_IDLE);
    ctrl.tmoBit     = (state == ST_TMO);
    ctrl.abtBit     = (state == ST_ABT);
  end

  assign busy        = (state == ST_PROG);
  assign timeoutFlag = (state == ST_TMO);
  assign abortFlag   = (state == ST_ABT);
  assign suspRead    = (state == ST_IDLE) && ctxQ;

endmodule

// File: rtl/flash_dp.sv
module flash_dp
  import flash_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8   // at least 8 so that the status byte fits
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  engCtrl_t                  ctrl,
  input  logic [ADDR_W-1:0]         progAddr,
  input  logic [DATA_W-1:0]         progData,
  input  logic                      stuckEn,
  input  logic [$clog2(DATA_W)-1:0] stuckIdx,
  input  logic [ADDR_W-1:0]         rdAddr,
  output logic [DATA_W-1:0]         rdData,
  output logic                      wordMatch
);

  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [WORDS];
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] targetQ;
  logic [DATA_W-1:0] curWord;
  logic [DATA_W-1:0] pinMask;
  logic [DATA_W-1:0] pulsedWord;
  logic [DATA_W-1:0] statusByte;

  assign curWord    = cells[addrQ];
  assign pinMask    = stuckEn ? (DATA_W'(1) << stuckIdx) : '0;
  // a pulse can only clear bits; a pinned bit keeps its old value
  assign pulsedWord = (curWord & dataQ) | (curWord & pinMask);
  assign wordMatch  = (curWord == targetQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ   <= '0;
      dataQ   <= '1;
      targetQ <= '1;
    end else if (ctrl.load) begin
      addrQ   <= progAddr;
      dataQ   <= progData;
      targetQ <= cells[progAddr] & progData;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_cell
    always_ff @(posedge clk) begin
      if (!rstN)                                       cells[w] <= '1;
      else if (ctrl.pulse && addrQ == ADDR_W'(w))      cells[w] <= pulsedWord;
    end
  end

  always_comb begin
    statusByte          = '0;
    statusByte[TMO_POS] = ctrl.tmoBit;
    statusByte[ABT_POS] = ctrl.abtBit;
  end

  assign rdData = ctrl.showStatus ? statusByte : cells[rdAddr];

endmodule

// File: rtl/flash_prog_engine.sv
module flash_prog_engine
  import flash_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int PULSE_LIMIT = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      progStb,
  input  logic [ADDR_W-1:0]         progAddr,
  input  logic [DATA_W-1:0]         progData,
  input  logic                      suspendCtx,
  input  logic                      resetCmdStb,
  input  logic                      abortStb,
  input  logic                      abortResetStb,
  input  logic                      stuckEn,
  input  logic [$clog2(DATA_W)-1:0] stuckIdx,
  input  logic [ADDR_W-1:0]         rdAddr,
  output logic [DATA_W-1:0]         rdData,
  output logic                      busy,
  output logic                      suspRead
);

  engCtrl_t ctrlS;
  logic     wordMatch;
  logic     timeoutFlag;
  logic     abortFlag;

  flash_ctrl #(.PULSE_LIMIT(PULSE_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .progStb(progStb), .suspendCtx(suspendCtx),
    .resetCmdStb(resetCmdStb), .abortStb(abortStb),
    .abortResetStb(abortResetStb), .wordMatch(wordMatch), .ctrl(ctrlS),
    .busy(busy), .suspRead(suspRead), .timeoutFlag(timeoutFlag),
    .abortFlag(abortFlag)
  );

  flash_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrlS), .progAddr(progAddr),
    .progData(progData), .stuckEn(stuckEn), .stuckIdx(stuckIdx),
    .rdAddr(rdAddr), .rdData(rdData), .wordMatch(wordMatch)
  );

endmodule

// File: rtl/flash_prog_chk.sv
module flash_prog_chk #(
  parameter int PULSE_LIMIT = 16,
  parameter int DATA_W      = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              progStb,
  input logic              resetCmdStb,
  input logic              abortResetStb,
  input logic              busy,
  input logic              timeoutFlag,
  input logic              abortFlag,
  input logic [DATA_W-1:0] rdData
);

  localparam int RUN_W = $clog2(PULSE_LIMIT + 3);
  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !timeoutFlag && !abortFlag && progStb) |=> busy);

  assert_busy_window_R7: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= RUN_W'(PULSE_LIMIT + 1));

  assert_tmo_from_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> $past(busy));

  assert_tmo_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag && !resetCmdStb) |=> timeoutFlag);

  assert_abt_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (abortFlag && !abortResetStb) |=> abortFlag);

  assert_status_R5: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutFlag || abortFlag) |-> (!busy && rdData[5] == timeoutFlag && rdData[1] == abortFlag));

  assert_err_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({busy, timeoutFlag, abortFlag}));

endmodule

bind flash_prog_engine flash_prog_chk #(.PULSE_LIMIT(PULSE_LIMIT), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .progStb(progStb), .resetCmdStb(resetCmdStb),
  .abortResetStb(abortResetStb), .busy(busy), .timeoutFlag(timeoutFlag),
  .abortFlag(abortFlag), .rdData(rdData)
);

// File: tb/sim_flash_prog_engine.sv
`timescale 1ns/1ps
module sim_flash_prog_engine;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int LIMIT  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic progStb = 1'b0, suspendCtx = 1'b0, resetCmdStb = 1'b0;
  logic abortStb = 1'b0, abortResetStb = 1'b0, stuckEn = 1'b0;
  logic [ADDR_W-1:0] progAddr = '0, rdAddr = '0;
  logic [DATA_W-1:0] progData = '0;
  logic [2:0] stuckIdx = '0;
  logic [DATA_W-1:0] rdData;
  logic busy, suspRead;

  int nChecks = 0;
  int nFail   = 0;
  int run;

  typedef struct { logic [DATA_W-1:0] exp; string tag; } item_t;
  item_t expQ[$];

  always #4 clk = ~clk;  // 125 MHz

  flash_prog_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_LIMIT(LIMIT)) u0 (
    .clk(clk), .rstN(rstN), .progStb(progStb), .progAddr(progAddr),
    .progData(progData), .suspendCtx(suspendCtx), .resetCmdStb(resetCmdStb),
    .abortStb(abortStb), .abortResetStb(abortResetStb), .stuckEn(stuckEn),
    .stuckIdx(stuckIdx), .rdAddr(rdAddr), .rdData(rdData), .busy(busy),
    .suspRead(suspRead)
  );

  // monitor: compares queued read expectations away from the active edge
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      item_t it;
      it = expQ.pop_front();
      nChecks++;
      if (rdData !== it.exp) begin
        nFail++;
        $display("FAIL %s rdData actual=%h expected=%h", it.tag, rdData, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic expectRd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string tag);
    item_t it;
    rdAddr = a;
    it.exp = e; it.tag = tag;
    expQ.push_back(it);
    tick();
  endtask

  task automatic checkVal(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic progReq(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input logic ctx);
    progStb = 1'b1; progAddr = a; progData = d; suspendCtx = ctx;
    tick();
    progStb = 1'b0; suspendCtx = 1'b0;
  endtask

  task automatic waitIdle(output int cnt);
    cnt = 0;
    while (busy && cnt < 100) begin cnt++; tick(); end
  endtask

  task automatic pulseIn(ref logic s);
    s = 1'b1; tick(); s = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog all-R actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    // R1: erased state
    checkVal("R1 busy", busy, 0);
    checkVal("R1 suspRead", suspRead, 0);
    expectRd(0, 8'hFF, "R1 word0");
    expectRd(7, 8'hFF, "R1 word7");

    // R2 / R5: plain clear on erased word, status during busy
    progReq(2, 8'hA5, 1'b0);
    checkVal("R2 busy after accept", busy, 1);
    expectRd(2, 8'h00, "R5 status while busy");
    waitIdle(run);
    expectRd(2, 8'hA5, "R2 stored old AND data");

    progReq(4, 8'h3C, 1'b0);
    waitIdle(run);
    checkVal("R2 busy cycles", run, 2);
    expectRd(4, 8'h3C, "R2 word4");

    // R3: mixed pattern, 0->1 masked
    progReq(2, 8'hF0, 1'b0);
    waitIdle(run);
    expectRd(2, 8'hA0, "R3 mask and clear");

    // R4: nothing to clear
    progReq(2, 8'hFF, 1'b0);
    waitIdle(run);
    checkVal("R4 busy cycles", run, 1);
    expectRd(2, 8'hA0, "R4 word unchanged no timeout");

    // R6: request during busy ignored
    progReq(1, 8'h0F, 1'b0);
    progStb = 1'b1; progAddr = 5; progData = 8'h00;
    tick();
    progStb = 1'b0;
    waitIdle(run);
    expectRd(5, 8'hFF, "R6 ignored while busy");
    expectRd(1, 8'h0F, "R6 first request kept");

    // R7: stuck bit forces timeout
    stuckEn = 1'b1; stuckIdx = 3'd0;
    progReq(3, 8'h00, 1'b0);
    waitIdle(run);
    checkVal("R7 busy cycles", run, LIMIT + 1);
    expectRd(0, 8'h20, "R7 timeout status");
    stuckEn = 1'b0;

    // R6 in error, R9 abort reset does not clear timeout
    progReq(6, 8'h00, 1'b0);
    pulseIn(abortResetStb);
    expectRd(0, 8'h20, "R9 abort reset ignored in timeout");
    pulseIn(resetCmdStb);
    checkVal("R8 suspRead after reset ctx0", suspRead, 0);
    expectRd(3, 8'h01, "R8 array read after reset");
    expectRd(6, 8'hFF, "R6 ignored in error");

    // R8: timeout in suspend context
    stuckEn = 1'b1; stuckIdx = 3'd7;
    progReq(7, 8'h00, 1'b1);
    waitIdle(run);
    expectRd(0, 8'h20, "R8 timeout held");
    stuckEn = 1'b0;
    tick();
    expectRd(0, 8'h20, "R8 timeout still held");
    pulseIn(resetCmdStb);
    checkVal("R8 suspRead after reset ctx1", suspRead, 1);
    expectRd(7, 8'h80, "R7 pinned bit kept");

    // R9: abort
    pulseIn(abortStb);
    checkVal("R9 suspRead in abort", suspRead, 0);
    expectRd(0, 8'h02, "R9 abort status");
    pulseIn(resetCmdStb);
    expectRd(0, 8'h02, "R9 reset cmd ignored");
    progReq(0, 8'h00, 1'b0);
    pulseIn(abortResetStb);
    checkVal("R9 busy after abort reset", busy, 0);
    expectRd(0, 8'hFF, "R9 array read, request ignored");
    checkVal("R9 suspRead after abort reset", suspRead, 0);

    // R8: success inside suspend context shows suspend read
    progReq(5, 8'h77, 1'b1);
    waitIdle(run);
    checkVal("R8 suspRead after success", suspRead, 1);
    expectRd(5, 8'h77, "R2 word5");

    tick();
    summary();
    $finish;
  end

endmodule